// File: doc/BRIEF.md
# Dual-Polynomial Serial CRC Engine

This block is a bit-serial cyclic redundancy check unit for a 10 Mb/s CSMA/CD media access controller. One register serves both directions. On transmit it builds the frame check sequence over the outgoing bits and then shifts that sequence out. On receive it absorbs every bit on the line, including the trailing check bits, and reports whether the register ended on the polynomial's fixed good-frame residue.

A static configuration input selects the 32-bit polynomial (04C11DB7 hex) or the 16-bit CCITT polynomial (1021 hex). A second configuration input suppresses insertion of the check sequence. Bits arrive one per `bit_vld` strobe, in transmission order, with the least significant bit of each byte first. A `sof` pulse presets the register for a new frame. An `eof_req` pulse starts the serial output of the check sequence, which is paced by the same strobe. A masked snapshot of the register is always visible for diagnostics.

Top module: `serial_crc_unit`

## Requirements
- R1: After reset the snapshot reads FFFFFFFF hex with `mode16`=0, and `fcs_active` and `good_frame` are low.
- R2: A `sof` pulse presets the register to all ones in the next cycle, whatever else is happening, and it also aborts an FCS output already in progress.
- R3: With `mode16`=0, each `bit_vld` strobe outside the FCS output absorbs `bit_in` into the register. The feedback is register bit 31 XOR `bit_in`. The register shifts left, and when the feedback is 1 it is XORed with 04C11DB7. The ASCII string "123456789", fed least significant bit first, leaves 9B63D02C.
- R4: With `mode16`=1, the same rule applies to register bits 15:0, with feedback from bit 15 and polynomial 1021. The snapshot then reads bits 31:16 as zero.
- R5: When `no_fcs`=0, an `eof_req` pulse raises `fcs_active` on the next cycle. It stays high for exactly 32 strobes (`mode16`=0) or 16 strobes (`mode16`=1). Before each strobe, `fcs_bit` equals the complement of register bit 31 (or bit 15).
- R6: Each FCS strobe shifts the register left and fills with zero, so once the whole FCS is out the meaningful part of the register is all zeros.
- R7: When `no_fcs`=1, `eof_req` has no effect: `fcs_active` stays low and the register is unchanged.
- R8: `good_frame` is high exactly when the register equals C704DD7B (`mode16`=0), or when its bits 15:0 equal 1D0F (`mode16`=1). It is valid on the cycle after the strobe of the last absorbed bit, so a frame followed by its own FCS reads high and a corrupted frame reads low.
- R9: With `bit_vld` and `sof` low, the register holds. During FCS output the value on `bit_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode16 | input | 1 | 0 selects the 32-bit polynomial, 1 selects the 16-bit CCITT polynomial |
| no_fcs | input | 1 | 1 suppresses FCS output on `eof_req` |
| sof | input | 1 | Start-of-frame pulse, presets the register to all ones |
| eof_req | input | 1 | Requests serial output of the FCS |
| bit_vld | input | 1 | Bit strobe |
| bit_in | input | 1 | Serial data bit, least significant bit first |
| fcs_active | output | 1 | High while FCS bits are being output |
| fcs_bit | output | 1 | Current FCS bit, valid while `fcs_active` is high |
| good_frame | output | 1 | Register holds the good-frame residue |
| crc_snap | output | 32 | Register snapshot, upper half zero in 16-bit mode |

## Verification
A wrong feedback tap or polynomial bit corrupts the snapshot within one strobe of the first data bit that reaches it. It shows as soon as the bench compares the snapshot after a frame. A fault in the FCS shifting shows up in two places: in the bit stream, as a mismatch with the complemented register top bit, and afterwards, as a non-zero register. A wrong FCS length shows as `fcs_active` falling early or late. Any of these errors also turns the loop-back of a frame plus its own FCS into a false `good_frame`, in the cycle right after the last bit.

// File: rtl/scrc_pkg.sv
package scrc_pkg;
  localparam int unsigned WIDE_W   = 32;
  localparam int unsigned NARROW_W = 16;
  localparam int unsigned CNT_W    = $clog2(WIDE_W + 1);
  localparam logic [WIDE_W-1:0]   POLY_WIDE   = 32'h04C1_1DB7;
  localparam logic [NARROW_W-1:0] POLY_NARROW = 16'h1021;
  localparam logic [WIDE_W-1:0]   RES_WIDE    = 32'hC704_DD7B;
  localparam logic [NARROW_W-1:0] RES_NARROW  = 16'h1D0F;
endpackage

// File: rtl/scrc_rst_sync.sv
module scrc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/scrc_step.sv
module scrc_step #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] POLY = '1
) (
  input  logic [W-1:0] cur,
  input  logic         din,
  output logic [W-1:0] nxt
);
  logic fb;

  always_comb begin
    fb  = cur[W-1] ^ din;
    nxt = {cur[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end
endmodule

// File: rtl/scrc_fcs_seq.sv
module scrc_fcs_seq #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  logic [CW-1:0] len,
  input  logic          step,
  output logic          active
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = clr | start | step;
    if (clr)        cnt_d = '0;
    else if (start) cnt_d = len;
    else if (step && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  p_start_arms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !clr && len != '0) |=> active);
  p_last_step_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start && !clr && cnt_q == CW'(1)) |=> !active);
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !active);
endmodule

// File: rtl/serial_crc_unit.sv
module serial_crc_unit
  import scrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode16,
  input  logic              no_fcs,
  input  logic              sof,
  input  logic              eof_req,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic              fcs_active,
  output logic              fcs_bit,
  output logic              good_frame,
  output logic [WIDE_W-1:0] crc_snap
);
  localparam logic [CNT_W-1:0] LEN_WIDE   = CNT_W'(WIDE_W);
  localparam logic [CNT_W-1:0] LEN_NARROW = CNT_W'(NARROW_W);

  logic                rst_s_n;
  logic [WIDE_W-1:0]   crc_q, crc_d;
  logic                crc_en;
  logic [WIDE_W-1:0]   nxt_wide;
  logic [NARROW_W-1:0] nxt_narrow;
  logic                seq_start;

  scrc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  scrc_step #(.W(WIDE_W), .POLY(POLY_WIDE)) u_step_wide (
    .cur(crc_q), .din(bit_in), .nxt(nxt_wide)
  );

  scrc_step #(.W(NARROW_W), .POLY(POLY_NARROW)) u_step_narrow (
    .cur(crc_q[NARROW_W-1:0]), .din(bit_in), .nxt(nxt_narrow)
  );

  assign seq_start = eof_req & ~no_fcs & ~fcs_active & ~sof;

  scrc_fcs_seq #(.CW(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_s_n), .clr(sof), .start(seq_start),
    .len(mode16 ? LEN_NARROW : LEN_WIDE),
    .step(bit_vld & fcs_active), .active(fcs_active)
  );

  always_comb begin
    crc_d  = crc_q;
    crc_en = sof | bit_vld;
    if (sof) begin
      crc_d = '1;
    end else if (bit_vld && fcs_active) begin
      if (mode16) crc_d = {crc_q[WIDE_W-1:NARROW_W], crc_q[NARROW_W-2:0], 1'b0};
      else        crc_d = {crc_q[WIDE_W-2:0], 1'b0};
    end else if (bit_vld) begin
      if (mode16) crc_d = {crc_q[WIDE_W-1:NARROW_W], nxt_narrow};
      else        crc_d = nxt_wide;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    crc_q <= '1;
    else if (crc_en) crc_q <= crc_d;
  end

  assign fcs_bit    = mode16 ? ~crc_q[NARROW_W-1] : ~crc_q[WIDE_W-1];
  assign good_frame = mode16 ? (crc_q[NARROW_W-1:0] == RES_NARROW)
                             : (crc_q == RES_WIDE);
  assign crc_snap   = mode16 ? {{(WIDE_W-NARROW_W){1'b0}}, crc_q[NARROW_W-1:0]}
                             : crc_q;

  p_preset_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    sof |=> (crc_q == '1));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!bit_vld && !sof) |=> $stable(crc_q));
  p_suppress_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (eof_req && no_fcs && !fcs_active) |=> !fcs_active);
  p_zero_after_fcs_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($fell(fcs_active) && !$past(sof)) |->
      (crc_q[NARROW_W-1:0] == '0) && (mode16 || crc_q[WIDE_W-1:NARROW_W] == '0));
endmodule

// File: tb/serial_crc_unit_test.sv
module serial_crc_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0, mode16 = 1'b0, no_fcs = 1'b0, sof = 1'b0;
  logic eof_req = 1'b0, bit_vld = 1'b0, bit_in = 1'b0;
  logic fcs_active, fcs_bit, good_frame;
  logic [31:0] crc_snap;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_crc_unit uut (
    .clk(clk), .rst_n(rst_n), .mode16(mode16), .no_fcs(no_fcs), .sof(sof),
    .eof_req(eof_req), .bit_vld(bit_vld), .bit_in(bit_in),
    .fcs_active(fcs_active), .fcs_bit(fcs_bit), .good_frame(good_frame),
    .crc_snap(crc_snap)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mstep(input logic [31:0] r, input bit d, input bit m16);
    logic [31:0] v;
    if (m16) begin
      v = {16'h0, r[14:0], 1'b0};
      if (r[15] ^ d) v[15:0] = v[15:0] ^ 16'h1021;
    end else begin
      v = {r[30:0], 1'b0};
      if (r[31] ^ d) v = v ^ 32'h04C11DB7;
    end
    return v;
  endfunction

  task automatic feed_bit(input bit b);
    @(negedge clk); bit_vld = 1'b1; bit_in = b;
    @(negedge clk); bit_vld = 1'b0;
  endtask

  task automatic feed_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) feed_bit(v[i]);
  endtask

  task automatic pulse_sof();
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
  endtask

  task automatic shift_fcs(input bit m16, inout logic [31:0] model, output bit fb[32]);
    int n;
    n = m16 ? 16 : 32;
    @(negedge clk); eof_req = 1'b1;
    @(negedge clk); eof_req = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk(fcs_active === 1'b1, "R5 fcs_active during output", {31'h0, fcs_active}, 32'h1);
      fb[i] = ~(m16 ? model[15] : model[31]);
      chk(fcs_bit === fb[i], "R5 fcs_bit value", {31'h0, fcs_bit}, {31'h0, fb[i]});
      bit_vld = 1'b1; bit_in = $urandom_range(0, 1);
      model = m16 ? {16'h0, model[14:0], 1'b0} : {model[30:0], 1'b0};
      @(negedge clk);
    end
    bit_vld = 1'b0;
    chk(fcs_active === 1'b0, "R5 fcs length ends output", {31'h0, fcs_active}, 32'h0);
    chk(crc_snap === 32'h0, "R6 register zero after fcs", crc_snap, 32'h0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] model, saved;
    logic [7:0]  data [12];
    bit          fb [32];
    string       s;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(crc_snap === 32'hFFFFFFFF, "R1 reset snapshot", crc_snap, 32'hFFFFFFFF);
    chk(fcs_active === 1'b0, "R1 reset fcs_active", {31'h0, fcs_active}, 32'h0);
    chk(good_frame === 1'b0, "R1 reset good_frame", {31'h0, good_frame}, 32'h0);

    // R3 known string
    s = "123456789";
    pulse_sof();
    for (int i = 0; i < 9; i++) feed_byte(s[i]);
    @(negedge clk);
    chk(crc_snap === 32'h9B63D02C, "R3 known vector", crc_snap, 32'h9B63D02C);

    // Sweep both modes and frame lengths: R3, R4, R5, R6, R8, R9
    for (int m = 0; m < 2; m++) begin
      for (int len = 1; len <= 12; len++) begin
        mode16 = m[0];
        pulse_sof();
        model = m[0] ? 32'h0000FFFF : 32'hFFFFFFFF;
        for (int i = 0; i < len; i++) begin
          data[i] = 8'($urandom);
          feed_byte(data[i]);
          for (int k = 0; k < 8; k++) model = mstep(model, data[i][k], m[0]);
        end
        chk(crc_snap === model, m[0] ? "R4 narrow register" : "R3 wide register", crc_snap, model);
        shift_fcs(m[0], model, fb);
        // loop-back of frame plus its FCS
        pulse_sof();
        for (int i = 0; i < len; i++) feed_byte(data[i]);
        for (int i = 0; i < (m[0] ? 16 : 32); i++) feed_bit(fb[i]);
        chk(good_frame === 1'b1, "R8 good frame after own fcs", {31'h0, good_frame}, 32'h1);
        chk(crc_snap === (m[0] ? 32'h00001D0F : 32'hC704DD7B), "R8 residue value", crc_snap,
            m[0] ? 32'h00001D0F : 32'hC704DD7B);
        // corrupted copy
        pulse_sof();
        for (int i = 0; i < len; i++) feed_byte(i == 0 ? data[0] ^ (8'h1 << (len % 8)) : data[i]);
        for (int i = 0; i < (m[0] ? 16 : 32); i++) feed_bit(fb[i]);
        chk(good_frame === 1'b0, "R8 corrupted frame rejected", {31'h0, good_frame}, 32'h0);
      end
    end

    // R7 suppression
    mode16 = 1'b0;
    pulse_sof();
    for (int i = 0; i < 3; i++) feed_byte(8'hA5 + 8'(i));
    @(negedge clk);
    saved = crc_snap;
    no_fcs = 1'b1;
    @(negedge clk); eof_req = 1'b1;
    @(negedge clk); eof_req = 1'b0;
    chk(fcs_active === 1'b0, "R7 no fcs output", {31'h0, fcs_active}, 32'h0);
    repeat (4) @(negedge clk);
    chk(fcs_active === 1'b0, "R7 still no fcs output", {31'h0, fcs_active}, 32'h0);
    chk(crc_snap === saved, "R7 register unchanged", crc_snap, saved);
    no_fcs = 1'b0;

    // R9 hold with toggling data and no strobe
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); bit_in = i[0];
    end
    @(negedge clk);
    chk(crc_snap === saved, "R9 hold without strobe", crc_snap, saved);

    // R2 abort of fcs output by sof
    @(negedge clk); eof_req = 1'b1;
    @(negedge clk); eof_req = 1'b0;
    for (int i = 0; i < 3; i++) begin
      bit_vld = 1'b1; @(negedge clk);
    end
    bit_vld = 1'b0;
    chk(fcs_active === 1'b1, "R5 output in progress", {31'h0, fcs_active}, 32'h1);
    pulse_sof();
    chk(fcs_active === 1'b0, "R2 sof aborts fcs", {31'h0, fcs_active}, 32'h0);
    chk(crc_snap === 32'hFFFFFFFF, "R2 sof presets ones", crc_snap, 32'hFFFFFFFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule